// File: doc/BRIEF.md
# Endian-Aware Load/Store Lane Aligner

This block sits between a 16-byte memory line and the register file. On the load side it takes one aligned 128-bit line, picks out the bytes of the addressed unit, orders them little- or big-endian as a per-access mode bit selects, and returns the value right-justified with all higher bits cleared, one cycle later. On the store side it does the reverse with no clock: it moves a right-justified register value into the addressed byte lanes of the line and produces a byte-enable mask for the write.

Access units are 1, 2, 4, 8, 10 and 16 bytes. Every access must start on its natural boundary, and the 10-byte unit must start on a 16-byte boundary. A separate fetch qualifier on the load side models instruction-bundle reads. These always take a whole 16-byte, little-endian line, whatever the size code and endian bit say. An access that breaks the alignment rule, or that carries an unused size code, raises an error flag and moves no data.

Top module: `ldst_lane_aligner`

## Requirements
- R1: The size code is 3 bits: 0=1 byte, 1=2, 2=4, 3=8, 4=10, 5=16 bytes. Codes 6 and 7 set the error flag on both the load and the store path.
- R2: For sizes of 1, 2, 4, 8 and 16 bytes, the error flag is set exactly when the byte offset (0..15) is not a multiple of the size.
- R3: A 10-byte access is in error at any offset other than 0.
- R4: With the endian bit at 0, result byte k equals line byte offset+k for k below the size. All result bits at or above 8×size are zero.
- R5: With the endian bit at 1, result byte k equals line byte offset+size-1-k for k below the size. All result bits at or above 8×size are zero.
- R6: With the fetch qualifier at 1, the load behaves as a 16-byte little-endian load, whatever the size code and the endian bit hold. It is in error at any nonzero offset.
- R7: The load outputs (data, error) are registered. The output valid follows the input valid one cycle later. Data and error hold their values in cycles with no input valid. Reset clears the valid, the data and the error.
- R8: A load in error returns all-zero data with the error flag set.
- R9: A legal store puts data byte k into lane offset+k (endian 0) or into lane offset+size-1-k (endian 1), for k below the size. All other lanes of the write data are zero. This path is combinational.
- R10: For a legal store, the 16-bit byte enable has exactly size consecutive bits set, starting at bit offset. Bit i corresponds to lane i, which is data bits 8i+7..8i.
- R11: A store in error has the error flag set, all byte enables clear and all write data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Load request present this cycle |
| ld_off_i | input | 4 | Byte offset of the load within the line |
| ld_size_i | input | 3 | Load size code |
| ld_big_i | input | 1 | Load byte order: 0 little, 1 big |
| ld_fetch_i | input | 1 | Bundle fetch: forces 16-byte little-endian |
| ld_line_i | input | 128 | Aligned memory line, lane i in bits 8i+7..8i |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 128 | Right-justified, zero-filled load value |
| ld_err_o | output | 1 | Load misaligned or illegal size |
| st_off_i | input | 4 | Byte offset of the store within the line |
| st_size_i | input | 3 | Store size code |
| st_big_i | input | 1 | Store byte order: 0 little, 1 big |
| st_data_i | input | 128 | Right-justified register value to store |
| st_wdata_o | output | 128 | Lane-positioned write data |
| st_be_o | output | 16 | Per-lane byte enable |
| st_err_o | output | 1 | Store misaligned or illegal size |

## Verification
The bench builds the block with its default 16-lane line. At that width every size code, including the two illegal ones and the 10-byte unit, can be tried at every one of the 16 offsets, so the full alignment table is reached. Random traffic with a bias toward aligned offsets is mixed with directed cases on a line whose byte i holds the value i, which makes misplaced or swapped bytes show directly in the data. Because the load path is registered, input-valid gaps show whether the output holds its value between loads.

// File: rtl/ldst_lane_aligner.sv
module ldst_lane_aligner #(
  parameter int LANES = 16,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_valid_i,
  input  logic [OFF_W-1:0]     ld_off_i,
  input  logic [2:0]           ld_size_i,
  input  logic                 ld_big_i,
  input  logic                 ld_fetch_i,
  input  logic [LANES*8-1:0]   ld_line_i,
  output logic                 ld_valid_o,
  output logic [LANES*8-1:0]   ld_data_o,
  output logic                 ld_err_o,
  input  logic [OFF_W-1:0]     st_off_i,
  input  logic [2:0]           st_size_i,
  input  logic                 st_big_i,
  input  logic [LANES*8-1:0]   st_data_i,
  output logic [LANES*8-1:0]   st_wdata_o,
  output logic [LANES-1:0]     st_be_o,
  output logic                 st_err_o
);
  localparam int DW = LANES * 8;

  // size code -> bytes; 0 marks an unused code
  function automatic int unit_bytes(input logic [2:0] code);
    case (code)
      3'd0: unit_bytes = 1;
      3'd1: unit_bytes = 2;
      3'd2: unit_bytes = 4;
      3'd3: unit_bytes = 8;
      3'd4: unit_bytes = 10;
      3'd5: unit_bytes = 16;
      default: unit_bytes = 0;
    endcase
  endfunction

  // offset bits that must be zero; the 10-byte unit needs a 16-byte boundary
  function automatic int align_mask(input logic [2:0] code);
    case (code)
      3'd0: align_mask = 0;
      3'd1: align_mask = 1;
      3'd2: align_mask = 3;
      3'd3: align_mask = 7;
      default: align_mask = 15;
    endcase
  endfunction

  // ---------------- load path ----------------
  logic [2:0]    ld_code;
  logic          ld_swap;
  int            ld_n;
  logic          ld_bad;
  logic [DW-1:0] ld_next;

  assign ld_code = ld_fetch_i ? 3'd5 : ld_size_i;
  assign ld_swap = ld_big_i & ~ld_fetch_i;
  assign ld_n    = unit_bytes(ld_code);
  assign ld_bad  = (ld_n == 0) || ((int'(ld_off_i) & align_mask(ld_code)) != 0);

  always_comb begin
    ld_next = '0;
    for (int k = 0; k < LANES; k++) begin
      int src;
      src = ld_swap ? int'(ld_off_i) + ld_n - 1 - k : int'(ld_off_i) + k;
      if (!ld_bad && k < ld_n && src < LANES)
        ld_next[k*8 +: 8] = ld_line_i[OFF_W'(src)*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid_o <= 1'b0;
      ld_data_o  <= '0;
      ld_err_o   <= 1'b0;
    end else begin
      ld_valid_o <= ld_valid_i;
      if (ld_valid_i) begin
        ld_data_o <= ld_next;
        ld_err_o  <= ld_bad;
      end
    end
  end

  // ---------------- store path ----------------
  int st_n;
  assign st_n     = unit_bytes(st_size_i);
  assign st_err_o = (st_n == 0) || ((int'(st_off_i) & align_mask(st_size_i)) != 0);

  always_comb begin
    st_wdata_o = '0;
    st_be_o    = '0;
    for (int j = 0; j < LANES; j++) begin
      int k;
      int src;
      k   = j - int'(st_off_i);
      src = st_big_i ? st_n - 1 - k : k;
      if (!st_err_o && k >= 0 && k < st_n && src >= 0 && src < LANES) begin
        st_be_o[j]          = 1'b1;
        st_wdata_o[j*8 +: 8] = st_data_i[OFF_W'(src)*8 +: 8];
      end
    end
  end

  // ---------------- assertions ----------------
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_i |=> ld_valid_o);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid_i |=> $stable(ld_data_o) && $stable(ld_err_o));
  p_err_zero_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o && ld_err_o |-> ld_data_o == '0);
  p_fetch_aligned_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_i && ld_fetch_i && ld_off_i == '0 |=> !ld_err_o);
  p_illegal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_size_i > 3'd5 |-> st_err_o);
  p_ten_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_size_i == 3'd4 && st_off_i != '0 |-> st_err_o);
  p_be_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_err_o |-> $countones(st_be_o) == unit_bytes(st_size_i));
  p_be_first_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !st_err_o |-> st_be_o[st_off_i]);
  p_err_blocks_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_err_o |-> st_be_o == '0 && st_wdata_o == '0);
endmodule

// File: tb/ldst_lane_aligner_tb.sv
module ldst_lane_aligner_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_valid = 1'b0;
  logic [3:0]   ld_off = '0;
  logic [2:0]   ld_size = '0;
  logic         ld_big = 1'b0;
  logic         ld_fetch = 1'b0;
  logic [127:0] ld_line = '0;
  logic         ld_valid_o;
  logic [127:0] ld_data_o;
  logic         ld_err_o;
  logic [3:0]   st_off = '0;
  logic [2:0]   st_size = '0;
  logic         st_big = 1'b0;
  logic [127:0] st_data = '0;
  logic [127:0] st_wdata_o;
  logic [15:0]  st_be_o;
  logic         st_err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ldst_lane_aligner u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid_i(ld_valid), .ld_off_i(ld_off), .ld_size_i(ld_size),
    .ld_big_i(ld_big), .ld_fetch_i(ld_fetch), .ld_line_i(ld_line),
    .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o), .ld_err_o(ld_err_o),
    .st_off_i(st_off), .st_size_i(st_size), .st_big_i(st_big),
    .st_data_i(st_data), .st_wdata_o(st_wdata_o), .st_be_o(st_be_o),
    .st_err_o(st_err_o)
  );

  function automatic int nbytes_of(input int s);
    case (s)
      0: return 1; 1: return 2; 2: return 4; 3: return 8; 4: return 10; 5: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_err(input int off, input int s);
    int n = nbytes_of(s);
    int a = (s == 4) ? 16 : n;
    if (n == 0) return 1'b1;
    return (off % a) != 0;
  endfunction

  function automatic logic [127:0] keep_low(input logic [127:0] v, input int n);
    logic [127:0] m;
    m = (n >= 16) ? '1 : ((128'd1 << (8 * n)) - 128'd1);
    return v & m;
  endfunction

  function automatic logic [127:0] reverse_bytes(input logic [127:0] v, input int n);
    logic [127:0] r = '0;
    for (int i = 0; i < n; i++) r[8*(n-1-i) +: 8] = v[8*i +: 8];
    return r;
  endfunction

  function automatic logic [127:0] ref_load(input logic [127:0] line, input int off,
                                            input int s, input bit big);
    logic [127:0] v;
    if (ref_err(off, s)) return '0;
    v = keep_low(line >> (8 * off), nbytes_of(s));
    return big ? reverse_bytes(v, nbytes_of(s)) : v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one-cycle reference pipeline for the load side
  logic         e_valid = 1'b0;
  logic [127:0] e_data = '0;
  logic         e_err = 1'b0;
  string        e_dtag = "R7";
  string        e_etag = "R7";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= 1'b0; e_data <= '0; e_err <= 1'b0;
      e_dtag <= "R7"; e_etag <= "R7";
    end else begin
      e_valid <= ld_valid;
      if (ld_valid) begin
        int s;
        bit b;
        s = ld_fetch ? 5 : int'(ld_size);
        b = ld_fetch ? 1'b0 : ld_big;
        e_data <= ref_load(ld_line, int'(ld_off), s, b);
        e_err  <= ref_err(int'(ld_off), s);
        e_dtag <= ld_fetch ? "R6" : ref_err(int'(ld_off), s) ? "R8" : b ? "R5" : "R4";
        e_etag <= ld_fetch ? "R6" : s > 5 ? "R1" : s == 4 ? "R3" : "R2";
      end else begin
        e_dtag <= "R7"; e_etag <= "R7";
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [127:0] sw;
      logic [15:0]  sbe;
      bit           se;
      int           n;
      check(ld_valid_o == e_valid, "R7 valid", 128'(ld_valid_o), 128'(e_valid));
      check(ld_data_o == e_data, e_dtag, ld_data_o, e_data);
      check(ld_err_o == e_err, e_etag, 128'(ld_err_o), 128'(e_err));
      se = ref_err(int'(st_off), int'(st_size));
      n  = nbytes_of(int'(st_size));
      if (se) begin
        sw = '0; sbe = '0;
      end else begin
        sw  = keep_low(st_data, n);
        if (st_big) sw = reverse_bytes(sw, n);
        sw  = sw << (8 * int'(st_off));
        sbe = 16'(((32'd1 << n) - 32'd1) << int'(st_off));
      end
      check(st_err_o == se, st_size > 5 ? "R1 store" : st_size == 4 ? "R3 store" : "R2 store",
            128'(st_err_o), 128'(se));
      check(st_wdata_o == sw, se ? "R11 wdata" : "R9", st_wdata_o, sw);
      check(st_be_o == sbe, se ? "R11 be" : "R10", 128'(st_be_o), 128'(sbe));
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic load(input int off, input int s, input bit big, input bit fetch);
    step();
    ld_valid = 1'b1; ld_off = 4'(off); ld_size = 3'(s); ld_big = big; ld_fetch = fetch;
  endtask

  task automatic store(input int off, input int s, input bit big, input logic [127:0] d);
    st_off = 4'(off); st_size = 3'(s); st_big = big; st_data = d;
  endtask

  logic [127:0] ramp;

  initial begin
    for (int i = 0; i < 16; i++) ramp[8*i +: 8] = 8'(i);
    ld_line = ramp;
    @(negedge clk);
    // reset state, R7
    check(ld_valid_o == 1'b0, "R7 reset valid", 128'(ld_valid_o), 128'd0);
    check(ld_data_o == '0, "R7 reset data", ld_data_o, '0);
    check(ld_err_o == 1'b0, "R7 reset err", 128'(ld_err_o), 128'd0);
    #2 rst_n = 1'b1;

    // directed loads: R4, R5, R3, R1, R2, R6, R8
    load(4, 2, 0, 0);  store(4, 2, 0, 128'h11223344);
    load(4, 2, 1, 0);  store(4, 2, 1, 128'h11223344);
    load(0, 4, 1, 0);  store(0, 4, 1, {32'h0, 96'h0, 32'hA1B2C3D4} | (ramp >> 48));
    load(8, 4, 0, 0);  store(8, 4, 0, ramp);
    load(0, 6, 0, 0);  store(0, 7, 0, ramp);
    load(8, 7, 1, 0);  store(1, 1, 0, ramp);
    load(1, 1, 0, 0);  store(8, 3, 1, 128'h0102030405060708);
    load(0, 0, 1, 1);  store(0, 5, 1, ramp);
    load(8, 0, 0, 1);  store(15, 0, 1, 128'hFF);
    load(15, 0, 1, 0); store(12, 2, 0, 128'hDEADBEEF);
    load(12, 3, 0, 0); store(6, 2, 0, ramp);
    step(); ld_valid = 1'b0;
    step(); step();

    // random traffic with idle gaps
    for (int i = 0; i < 3000; i++) begin
      int s;
      int o;
      step();
      s = int'($urandom_range(0, 7));
      o = int'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) o = (s == 4) ? 0 : o & ~(nbytes_of(s) > 0 ? nbytes_of(s) - 1 : 0);
      ld_valid = ($urandom_range(0, 3) != 0);
      ld_off = 4'(o); ld_size = 3'(s);
      ld_big = 1'($urandom); ld_fetch = ($urandom_range(0, 7) == 0);
      ld_line = {$urandom, $urandom, $urandom, $urandom};
      s = int'($urandom_range(0, 7));
      o = int'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) o = (s == 4) ? 0 : o & ~(nbytes_of(s) > 0 ? nbytes_of(s) - 1 : 0);
      store(o, s, 1'($urandom), {$urandom, $urandom, $urandom, $urandom});
    end
    step(); ld_valid = 1'b0;
    step(); step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule